// File: doc/BRIEF.md
# Fast GPIO Output Register Bank

This block keeps the drive level of a small group of general-purpose output channels (eight by default) and lets a processor bus change them atomically in three ways: a whole-word overwrite, a write that carries a value field and a mask field, and a command word with a 2-bit field per channel that sets, clears or inverts that channel. A per-channel enable register hands chosen channels to a second, instruction-driven data path. When that path is active it overwrites the levels of the enabled channels in the same clock.

The bus side is a single-cycle write strobe with an address and a data word. The read data is combinational from the address. Every accepted update becomes visible on the pins at the clock edge that accepts it. The block has no state machine: its only sequential state is the level register and the enable register.

Top module: `gpo_bank`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, all pin levels and all enable bits become 0.
- R2: A write to address 0 (direct) replaces every pin level with `reg_wdata[7:0]` at the accepting edge.
- R3: A write to address 1 (masked) loads `reg_wdata[i]` into channel i only where mask bit `reg_wdata[8+i]` is 1. All other channels keep their level.
- R4: A write to address 2 (command) reads the field `reg_wdata[2i+1:2i]` for channel i. Code 1 drives the channel high, code 2 drives it low, code 3 inverts it, and code 0 leaves it unchanged.
- R5: In one command word, all channel fields act in the same edge and independently of each other.
- R6: Address 3 holds the 8-bit instruction-path enable register. It is written from `reg_wdata[7:0]` and read back on `reg_rdata[7:0]`.
- R7: When `instr_valid` is high, every channel whose enable bit is 1 takes `instr_data[i]` at the edge. Channels whose enable bit is 0 ignore the instruction path.
- R8: When the instruction path and a register write hit the same enabled channel in one cycle, the instruction path wins. Channels that are not enabled still take the register update.
- R9: Reading address 4 returns the current pin levels in `reg_rdata[7:0]`. Unused addresses read 0. Writes to address 4 or to unused addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| instr_valid | input | 1 | Instruction-path update strobe |
| instr_data | input | 8 | Instruction-path levels |
| pin_out | output | 8 | Pin drive levels |

## Verification
The assertions assume that reset is held high on the first clock edge and that every input is at a defined 0 or 1 on each sampled edge. They also assume that a cycle with a register write and no `instr_valid` belongs to the register path alone. The bench drives all inputs on the falling edge from a known idle value, starts in reset, and keeps `instr_valid` low in every scenario except the instruction and conflict tests. As a result, the register-only properties are checked on cycles with a clean source.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_DIRECT = 3'd0,
        ADR_MASKED = 3'd1,
        ADR_CMD    = 3'd2,
        ADR_ENABLE = 3'd3,
        ADR_STATUS = 3'd4
    } gpo_addr_e;

    typedef enum logic [1:0] {
        CMD_KEEP  = 2'd0,
        CMD_SET   = 2'd1,
        CMD_CLEAR = 2'd2,
        CMD_FLIP  = 2'd3
    } gpo_cmd_e;
endpackage

// File: rtl/gpo_write_decode.sv
// Turns one bus write into a per-channel update mask and update value.
module gpo_write_decode
    import gpo_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned DW  = 32
) (
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DW-1:0]        wdata,
    input  logic [NCH-1:0]       levels,
    output logic [NCH-1:0]       upd_mask,
    output logic [NCH-1:0]       upd_val
);
    logic [NCH-1:0] cmd_mask;
    logic [NCH-1:0] cmd_val;

    // Command word: one 2-bit field per channel at offset 2*channel.
    for (genvar c = 0; c < NCH; c++) begin : g_cmd
        gpo_cmd_e code;
        assign code = gpo_cmd_e'(wdata[2*c +: 2]);
        always_comb begin
            unique case (code)
                CMD_SET:   begin cmd_mask[c] = 1'b1; cmd_val[c] = 1'b1;       end
                CMD_CLEAR: begin cmd_mask[c] = 1'b1; cmd_val[c] = 1'b0;       end
                CMD_FLIP:  begin cmd_mask[c] = 1'b1; cmd_val[c] = ~levels[c]; end
                default:   begin cmd_mask[c] = 1'b0; cmd_val[c] = levels[c];  end
            endcase
        end
    end

    always_comb begin
        upd_mask = '0;
        upd_val  = levels;
        if (we) begin
            case (addr)
                ADR_DIRECT: begin
                    upd_mask = '1;
                    upd_val  = wdata[NCH-1:0];
                end
                ADR_MASKED: begin
                    upd_mask = wdata[NCH +: NCH];
                    upd_val  = wdata[NCH-1:0];
                end
                ADR_CMD: begin
                    upd_mask = cmd_mask;
                    upd_val  = cmd_val;
                end
                default: begin
                    upd_mask = '0;
                    upd_val  = levels;
                end
            endcase
        end
    end
endmodule

// File: rtl/gpo_enable_reg.sv
// Per-channel enable for the instruction-driven path.
module gpo_enable_reg
    import gpo_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned DW  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [NCH-1:0]    en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en <= '0;
        end else if (we && addr == ADR_ENABLE) begin
            en <= wdata[NCH-1:0];
        end
    end

    // R6: the enable register moves only on a write to its address
    a_r6_enable_hold: assert property (@(posedge clk) disable iff (rst)
        (!rst && !(we && addr == ADR_ENABLE)) |=> $stable(en));
endmodule

// File: rtl/gpo_level_reg.sv
// Output level register: the instruction path has priority on enabled channels.
module gpo_level_reg #(
    parameter int unsigned NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] upd_mask,
    input  logic [NCH-1:0] upd_val,
    input  logic           instr_valid,
    input  logic [NCH-1:0] instr_data,
    input  logic [NCH-1:0] en,
    output logic [NCH-1:0] levels
);
    logic [NCH-1:0] nxt;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_comb begin
            if (instr_valid && en[c]) begin
                nxt[c] = instr_data[c];
            end else if (upd_mask[c]) begin
                nxt[c] = upd_val[c];
            end else begin
                nxt[c] = levels[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            levels <= '0;
        end else begin
            levels <= nxt;
        end
    end

    // R7/R8: enabled channels follow the instruction path whatever else is written
    a_r8_instr_wins: assert property (@(posedge clk) disable iff (rst)
        (!rst && instr_valid) |=> (((levels ^ $past(instr_data)) & $past(en)) == '0));

    // R7: without any update request, disabled channels hold their level
    a_r7_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        (!rst && upd_mask == '0) |=> (((levels ^ $past(levels)) & ~$past(en)) == '0));
endmodule

// File: rtl/gpo_bank.sv
module gpo_bank
    import gpo_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned DW  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              instr_valid,
    input  logic [NCH-1:0]    instr_data,
    output logic [NCH-1:0]    pin_out
);
    logic [NCH-1:0] en;
    logic [NCH-1:0] upd_mask;
    logic [NCH-1:0] upd_val;

    gpo_write_decode #(.NCH(NCH), .DW(DW)) u_dec (
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .levels   (pin_out),
        .upd_mask (upd_mask),
        .upd_val  (upd_val)
    );

    gpo_enable_reg #(.NCH(NCH), .DW(DW)) u_en (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .en    (en)
    );

    gpo_level_reg #(.NCH(NCH)) u_lvl (
        .clk         (clk),
        .rst         (rst),
        .upd_mask    (upd_mask),
        .upd_val     (upd_val),
        .instr_valid (instr_valid),
        .instr_data  (instr_data),
        .en          (en),
        .levels      (pin_out)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_ENABLE: reg_rdata[NCH-1:0] = en;
            ADR_STATUS: reg_rdata[NCH-1:0] = pin_out;
            default:    reg_rdata = '0;
        endcase
    end

    // R1: reset clears levels and enables
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (pin_out == '0 && en == '0));

    // R2: direct write lands on all pins
    a_r2_direct: assert property (@(posedge clk) disable iff (rst)
        (!rst && reg_we && reg_addr == ADR_DIRECT && !instr_valid)
        |=> pin_out == $past(reg_wdata[NCH-1:0]));

    // R3: masked write leaves unmasked channels alone
    a_r3_masked_keep: assert property (@(posedge clk) disable iff (rst)
        (!rst && reg_we && reg_addr == ADR_MASKED && !instr_valid)
        |=> (((pin_out ^ $past(pin_out)) & ~$past(reg_wdata[NCH +: NCH])) == '0));

    // R9: status and unused addresses never move the pins
    a_r9_status_nowrite: assert property (@(posedge clk) disable iff (rst)
        (!rst && reg_we && reg_addr >= ADR_STATUS && !instr_valid)
        |=> $stable(pin_out));
endmodule

// File: tb/gpo_bank_bench.sv
module gpo_bank_bench;
    localparam int NCH = 8;
    localparam int DW  = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           reg_we = 1'b0;
    logic [2:0]     reg_addr = '0;
    logic [DW-1:0]  reg_wdata = '0;
    logic [DW-1:0]  reg_rdata;
    logic           instr_valid = 1'b0;
    logic [NCH-1:0] instr_data = '0;
    logic [NCH-1:0] pin_out;

    int n_checks = 0;
    int n_errors = 0;
    logic [NCH-1:0] m_lvl = '0;
    logic [NCH-1:0] m_en  = '0;

    always #4 clk = ~clk;

    gpo_bank u_gpo_bank (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .instr_valid(instr_valid), .instr_data(instr_data), .pin_out(pin_out)
    );

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // One write cycle, optionally with the instruction path in the same cycle.
    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d,
                      input logic iv, input logic [NCH-1:0] idata);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        instr_valid = iv; instr_data = idata;
        @(negedge clk);
        reg_we = 1'b0; instr_valid = 1'b0; reg_wdata = '0; instr_data = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [NCH-1:0] apply_cmd(input logic [NCH-1:0] cur, input logic [DW-1:0] w);
        logic [NCH-1:0] r = cur;
        for (int c = 0; c < NCH; c++) begin
            case (w[2*c +: 2])
                2'd1: r[c] = 1'b1;
                2'd2: r[c] = 1'b0;
                2'd3: r[c] = ~cur[c];
                default: r[c] = cur[c];
            endcase
        end
        return r;
    endfunction

    task automatic t_reset();
        logic [DW-1:0] d;
        check("R1 pins after reset", pin_out, 0);
        rd(3'd3, d); check("R1 enable after reset", d, 0);
        rd(3'd4, d); check("R1 status after reset", d, 0);
    endtask

    task automatic t_direct();
        wr(3'd0, 32'hFFFF_FFA5, 1'b0, '0); m_lvl = 8'hA5;
        check("R2 direct A5", pin_out, m_lvl);
        wr(3'd0, 32'h0000_003C, 1'b0, '0); m_lvl = 8'h3C;
        check("R2 direct 3C", pin_out, m_lvl);
    endtask

    task automatic t_masked();
        wr(3'd1, {16'h0, 8'h0F, 8'hF0}, 1'b0, '0); m_lvl = 8'h30;
        check("R3 masked low nibble", pin_out, m_lvl);
        wr(3'd1, {16'h0, 8'h81, 8'hFF}, 1'b0, '0); m_lvl = 8'hB1;
        check("R3 masked ends", pin_out, m_lvl);
        wr(3'd1, {16'h0, 8'h00, 8'h4E}, 1'b0, '0);
        check("R3 empty mask", pin_out, m_lvl);
    endtask

    task automatic t_cmd();
        wr(3'd2, 32'h2 << 0, 1'b0, '0); m_lvl = 8'hB0;
        check("R4 clear ch0", pin_out, m_lvl);
        wr(3'd2, 32'h1 << 2, 1'b0, '0); m_lvl = 8'hB2;
        check("R4 set ch1", pin_out, m_lvl);
        wr(3'd2, 32'h3 << 14, 1'b0, '0); m_lvl = 8'h32;
        check("R4 toggle ch7", pin_out, m_lvl);
        wr(3'd2, 32'h0, 1'b0, '0);
        check("R4 all keep", pin_out, m_lvl);
    endtask

    task automatic t_multi();
        logic [DW-1:0] w;
        w = (32'h1 << 4) | (32'h2 << 8) | (32'h3 << 10) | (32'h3 << 12) | (32'h1 << 0);
        m_lvl = apply_cmd(m_lvl, w);
        wr(3'd2, w, 1'b0, '0);
        check("R5 mixed command word", pin_out, m_lvl);
        w = 32'hFFFF;
        m_lvl = apply_cmd(m_lvl, w);
        wr(3'd2, w, 1'b0, '0);
        check("R5 toggle all", pin_out, m_lvl);
    endtask

    task automatic t_enable();
        logic [DW-1:0] d;
        wr(3'd3, 32'hFFFF_FF0F, 1'b0, '0); m_en = 8'h0F;
        rd(3'd3, d); check("R6 enable readback", d, {24'h0, m_en});
        check("R6 pins untouched", pin_out, m_lvl);
    endtask

    task automatic t_instr();
        @(negedge clk);
        instr_valid = 1'b1; instr_data = 8'hFF;
        @(negedge clk);
        instr_valid = 1'b0; instr_data = '0;
        m_lvl = (m_lvl & ~m_en) | (8'hFF & m_en);
        check("R7 enabled channels follow", pin_out, m_lvl);
        @(negedge clk);
        instr_valid = 1'b1; instr_data = 8'h00;
        @(negedge clk);
        instr_valid = 1'b0;
        m_lvl = m_lvl & ~m_en;
        check("R7 disabled channels ignore", pin_out, m_lvl);
    endtask

    task automatic t_conflict();
        wr(3'd0, 32'h0000_0000, 1'b1, 8'hFF);
        m_lvl = 8'h0F;
        check("R8 instr wins on enabled", pin_out, m_lvl);
        wr(3'd0, 32'h0000_00F5, 1'b1, 8'h00);
        m_lvl = 8'hF0;
        check("R8 register on disabled", pin_out, m_lvl);
    endtask

    task automatic t_status();
        logic [DW-1:0] d;
        rd(3'd4, d); check("R9 status read", d, {24'h0, m_lvl});
        wr(3'd4, 32'hFFFF_FFFF, 1'b0, '0);
        check("R9 status write ignored", pin_out, m_lvl);
        wr(3'd7, 32'hFFFF_FFFF, 1'b0, '0);
        check("R9 unused write ignored", pin_out, m_lvl);
        rd(3'd7, d); check("R9 unused reads zero", d, 0);
        rd(3'd3, d); check("R9 enable untouched", d, {24'h0, m_en});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direct();
        t_masked();
        t_cmd();
        t_multi();
        t_enable();
        t_instr();
        t_conflict();
        t_status();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end
endmodule